// File: doc/BRIEF.md
# I2C Combined Register-Read Master

This block is the controller side of a two-wire serial bus. For each request it selects one 7-bit target, writes one register index to it, turns the bus around with a repeated START so that no other controller can take the bus in between, and reads back a chosen number of bytes. Both bus wires are treated as open-drain. For each wire the block has one output that enables a pull-low, and one input that samples the level on the wire. Both inputs pass through a short synchronizer before the state machine uses them.

The host raises `start_i` for one cycle, with the target address, the register index and the byte count on the same cycle. Each received byte appears on `rd_data_o` and is marked by a one-cycle `rd_valid_o`. `done_o` pulses once when the transfer has ended. `err_o` then says whether the transfer failed, either because the target refused a byte or because arbitration was lost. The length of one SCL half-period is set by `HALF_CYC`, in system clock cycles, and must be at least 4. A target may hold SCL low to stretch the clock; the half-period counter stops while the block has released SCL and still reads it low.

Top module: `i2c_rr_master`

## Requirements
- R1: The first address byte on the wire is {addr_i, 1'b0} (write) and the second is {addr_i, 1'b1} (read). Every byte is shifted out MSB first and is followed by a ninth clock, the acknowledge slot, in which a low SDA means acknowledge.
- R2: One transfer is, in this order: START, write address, the register index (reg_i), a repeated START with no STOP before it, read address, count_i data bytes, STOP. START and repeated START are SDA falling while SCL is high; STOP is SDA rising while SCL is high.
- R3: Apart from the START, repeated START and STOP conditions, SDA never changes while SCL is high. The only SDA edges with SCL high are therefore two starts and at most one stop.
- R4: In the acknowledge slot of every read byte except the last, the block pulls SDA low. After the last byte it leaves SDA released (NACK) and then issues STOP. A count_i of 0 is handled as 1.
- R5: Each received byte appears exactly once on rd_data_o, assembled MSB first, during a single-cycle rd_valid_o pulse, in the order the bytes were received.
- R6: While the block has released SCL but reads it low, its bit timing stays frozen. Every SCL high interval that the block ends by pulling SCL low lasts at least HALF_CYC cycles.
- R7: If the acknowledge slot of either address byte or of the register index reads high (NACK), the block issues STOP, delivers no read data, and ends with done_o and err_o both high.
- R8: If the block releases SDA to send a 1 but samples SDA low, it has lost arbitration. On the next cycle it releases both wires, issues no STOP, and ends with done_o and err_o both high.
- R9: done_o is a single-cycle pulse, one per transfer. On success it comes after STOP, with both wires released and err_o low.
- R10: start_i is ignored while a transfer is in progress.
- R11: After reset both pull-low outputs are inactive, and done_o and rd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a transfer |
| addr_i | input | 7 | Target address |
| reg_i | input | 8 | Register index written before the read |
| count_i | input | CNT_W | Number of bytes to read (0 is handled as 1) |
| rd_data_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte this cycle |
| done_o | output | 1 | Transfer finished, one-cycle pulse |
| err_o | output | 1 | Last transfer ended on NACK or on lost arbitration |
| scl_i | input | 1 | Sampled level of the clock wire |
| scl_pull_o | output | 1 | Pull the clock wire low |
| sda_i | input | 1 | Sampled level of the data wire |
| sda_pull_o | output | 1 | Pull the data wire low |

## Verification
The assertions assume that the wire inputs reflect a wired-AND of the block's own pull-low outputs and those of the other bus agents. They also assume that start_i, addr_i, reg_i and count_i hold stable values on the cycle of the request. The stimulus follows both rules. The bench builds each wire from the block's pull-low output and the target model's own pull, and it changes host inputs only between clock edges. The target model changes SDA only after it sees SCL fall, and it stretches only by holding SCL low after a falling edge. Arbitration loss is produced by a competing pull on SDA from the moment START is seen, so the block meets it on its first 1 bit and never in a bit it drives low itself.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START_A,
    ST_START_B,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_RS_LO,
    ST_RS_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_REL
  } rr_state_e;

  // phase order is the wire order of the combined read
  typedef enum logic [1:0] {
    PH_ADDR_W,
    PH_INDEX,
    PH_ADDR_R,
    PH_DATA
  } rr_phase_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // idle bus level is high, so flops reset to ones
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '1;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
  parameter int HALF_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic hold_i,
  output logic expire_o
);

  localparam int TW = $clog2(HALF_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i)                 cnt_q <= '0;
    else if (!hold_i && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == LAST) && !hold_i;

  AST_STRETCH_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !restart_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift import i2c_rr_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic              msb_o,
  output logic [BYTE_W-1:0] next_o
);

  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= next_o;
  end

  assign msb_o  = sr_q[BYTE_W-1];
  assign next_o = {sr_q[BYTE_W-2:0], bit_i};

endmodule

// File: rtl/i2c_rr_master.sv
module i2c_rr_master import i2c_rr_pkg::*; #(
  parameter int HALF_CYC    = 250,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [6:0]       addr_i,
  input  logic [7:0]       reg_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  input  logic             scl_i,
  output logic             scl_pull_o,
  input  logic             sda_i,
  output logic             sda_pull_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic scl_s, sda_s;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    ({scl_s, sda_s})
  );

  rr_state_e        state_q;
  rr_phase_e        phase_q;
  logic             scl_pull_q, sda_pull_q;
  logic [3:0]       bit_q;
  logic [CNT_W-1:0] rem_q;
  logic [6:0]       addr_q;
  logic [7:0]       idx_q;
  logic             err_q, done_q, valid_q;
  logic [7:0]       rdata_q;

  logic step, hold, restart;

  // released SCL still seen low: target is stretching
  assign hold    = !scl_pull_q && !scl_s;
  assign restart = (state_q == ST_IDLE) || step;

  i2c_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .hold_i    (hold),
    .expire_o  (step)
  );

  logic tx_phase, ack_slot, hi_end, arb_lost, nack_seen;
  logic sh_load, sh_shift, sh_msb, drive_val;
  logic [7:0] sh_load_val, sh_next;

  assign tx_phase  = (phase_q != PH_DATA);
  assign ack_slot  = bit_q[3];
  assign hi_end    = (state_q == ST_BIT_HI) && step;
  assign arb_lost  = hi_end && tx_phase && !ack_slot && !sda_pull_q && !sda_s;
  assign nack_seen = hi_end && tx_phase && ack_slot && sda_s;

  assign sh_load = (state_q == ST_START_B && step) ||
                   (hi_end && ack_slot && phase_q == PH_ADDR_W && !sda_s);
  assign sh_load_val = (state_q == ST_START_B) ? {addr_q, phase_q == PH_ADDR_R} : idx_q;
  assign sh_shift = hi_end && !ack_slot && !arb_lost;

  i2c_byte_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sh_load),
    .load_val_i (sh_load_val),
    .shift_i    (sh_shift),
    .bit_i      (sda_s),
    .msb_o      (sh_msb),
    .next_o     (sh_next)
  );

  // SDA pull wanted during the low half of the current bit
  always_comb begin
    if (tx_phase) drive_val = ack_slot ? 1'b0 : !sh_msb;
    else          drive_val = ack_slot ? (rem_q != ONE) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR_W;
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
      bit_q      <= '0;
      rem_q      <= ONE;
      addr_q     <= '0;
      idx_q      <= '0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      valid_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          scl_pull_q <= 1'b0;
          sda_pull_q <= 1'b0;
          if (start_i) begin
            addr_q  <= addr_i;
            idx_q   <= reg_i;
            rem_q   <= (count_i == '0) ? ONE : count_i;
            err_q   <= 1'b0;
            phase_q <= PH_ADDR_W;
            state_q <= ST_START_A;
          end
        end
        ST_START_A: if (step) begin
          sda_pull_q <= 1'b1;
          state_q    <= ST_START_B;
        end
        ST_START_B: if (step) begin
          scl_pull_q <= 1'b1;
          bit_q      <= '0;
          state_q    <= ST_BIT_LO;
        end
        ST_BIT_LO: begin
          sda_pull_q <= drive_val;
          if (step) begin
            scl_pull_q <= 1'b0;
            state_q    <= ST_BIT_HI;
          end
        end
        ST_BIT_HI: if (step) begin
          if (arb_lost) begin
            scl_pull_q <= 1'b0;
            sda_pull_q <= 1'b0;
            err_q      <= 1'b1;
            done_q     <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (!ack_slot) begin
            if (!tx_phase && bit_q == 4'd7) begin
              valid_q <= 1'b1;
              rdata_q <= sh_next;
            end
            bit_q      <= bit_q + 1'b1;
            scl_pull_q <= 1'b1;
            state_q    <= ST_BIT_LO;
          end else begin
            scl_pull_q <= 1'b1;
            bit_q      <= '0;
            if (nack_seen) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP_LO;
            end else begin
              unique case (phase_q)
                PH_ADDR_W: begin
                  phase_q <= PH_INDEX;
                  state_q <= ST_BIT_LO;
                end
                PH_INDEX:  state_q <= ST_RS_LO;
                PH_ADDR_R: begin
                  phase_q <= PH_DATA;
                  state_q <= ST_BIT_LO;
                end
                default: begin
                  if (rem_q == ONE) state_q <= ST_STOP_LO;
                  else begin
                    rem_q   <= rem_q - 1'b1;
                    state_q <= ST_BIT_LO;
                  end
                end
              endcase
            end
          end
        end
        ST_RS_LO: begin
          sda_pull_q <= 1'b0;
          if (step) begin
            scl_pull_q <= 1'b0;
            state_q    <= ST_RS_HI;
          end
        end
        ST_RS_HI: if (step) begin
          sda_pull_q <= 1'b1;
          phase_q    <= PH_ADDR_R;
          state_q    <= ST_START_B;
        end
        ST_STOP_LO: begin
          sda_pull_q <= 1'b1;
          if (step) begin
            scl_pull_q <= 1'b0;
            state_q    <= ST_STOP_HI;
          end
        end
        ST_STOP_HI: if (step) begin
          sda_pull_q <= 1'b0;
          state_q    <= ST_STOP_REL;
        end
        ST_STOP_REL: if (step) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_pull_o = scl_pull_q;
  assign sda_pull_o = sda_pull_q;
  assign rd_data_o  = rdata_q;
  assign rd_valid_o = valid_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT_HI && $past(state_q) == ST_BIT_HI) |-> $stable(sda_pull_q)); // R3

  AST_VALID_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (phase_q == PH_DATA)); // R5

  AST_NACK_TO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_seen |=> (state_q == ST_STOP_LO && err_q)); // R7

  AST_ARB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost |=> (!scl_pull_q && !sda_pull_q && err_q && done_q)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9

  AST_DONE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !err_q) |-> ($past(state_q) == ST_STOP_REL)); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(addr_q)); // R10

endmodule

// File: tb/sim_i2c_rr_master.sv
`timescale 1ns/1ps
module sim_i2c_rr_master;

  localparam int HALF  = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start = 1'b0;
  logic [6:0]       addr  = '0;
  logic [7:0]       regi  = '0;
  logic [CNT_W-1:0] cnt   = '0;
  logic [7:0]       rd_data;
  logic             rd_valid, done, err, scl_pull, sda_pull;
  logic             tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
  logic             scl_line, sda_line;

  assign scl_line = !(scl_pull || tgt_scl_low);
  assign sda_line = !(sda_pull || tgt_sda_low);

  i2c_rr_master #(.HALF_CYC(HALF), .CNT_W(CNT_W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .reg_i(regi),
    .count_i(cnt), .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done),
    .err_o(err), .scl_i(scl_line), .scl_pull_o(scl_pull), .sda_i(sda_line),
    .sda_pull_o(sda_pull)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tgt_byte(input int k);
    return 8'h3C ^ 8'(k * 91);
  endfunction

  // target model knobs and records
  int nack_at = 0, stretch_len = 0;
  bit arb_en = 0, arb_hold = 0;
  logic [7:0] got[$];
  bit mack_q[$];
  int starts = 0, rs_cnt = 0, stops = 0, tx_k = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int bitn = 0, str_cnt = 0, seg_byte = 0;
  bit in_xfer = 0, tx_on = 0, pend_tx = 0, mnack = 0, ack_given = 0;
  logic [7:0] shreg = '0, cur = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!arb_en && arb_hold) begin tgt_sda_low = 1'b0; arb_hold = 0; end
      if (str_cnt > 0) begin
        str_cnt--;
        if (str_cnt == 0) tgt_scl_low = 1'b0;
      end
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        if (in_xfer) rs_cnt++;
        if (arb_en && !in_xfer) begin tgt_sda_low = 1'b1; arb_hold = 1; end
        else tgt_sda_low = 1'b0;
        starts++; in_xfer = 1; bitn = -1; seg_byte = 0;
        tx_on = 0; pend_tx = 0; mnack = 0;
      end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
        stops++; in_xfer = 0; tx_on = 0; tgt_sda_low = 1'b0;
      end else if (in_xfer && !prev_scl && scl_line) begin
        if (bitn >= 0 && bitn < 8) begin
          if (!tx_on) shreg = {shreg[6:0], sda_line};
        end else if (bitn == 8 && tx_on) begin
          mack_q.push_back(!sda_line);
          mnack = sda_line;
        end
      end else if (in_xfer && prev_scl && !scl_line) begin
        if (stretch_len > 0) begin tgt_scl_low = 1'b1; str_cnt = stretch_len; end
        bitn++;
        if (bitn == 8) begin
          if (!tx_on) begin
            got.push_back(shreg);
            seg_byte++;
            ack_given = (nack_at != got.size());
            tgt_sda_low = ack_given;
            if (seg_byte == 1 && shreg[0] && ack_given) pend_tx = 1;
          end else tgt_sda_low = 1'b0;
        end else if (bitn == 9) begin
          bitn = 0;
          tgt_sda_low = 1'b0;
          if (pend_tx) begin tx_on = 1; pend_tx = 0; end
          else if (tx_on && mnack) tx_on = 0;
          if (tx_on) begin
            cur = tgt_byte(tx_k);
            tx_k++;
            tgt_sda_low = !cur[7];
          end
        end else if (tx_on && bitn > 0 && bitn < 8) begin
          tgt_sda_low = !cur[7-bitn];
        end
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  // scoreboard and bus monitors
  logic [7:0] exp_q[$];
  bit busy = 0;
  int hi_run = 0, min_high = 1000000, done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5", "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R5", "read byte", rd_data, e);
      end
    end
    if (rst_n && done) done_cnt++;
    if (busy) begin
      if (scl_line) hi_run++;
      else begin
        if (hi_run > 0 && hi_run < min_high) min_high = hi_run;
        hi_run = 0;
      end
    end
  end

  task automatic run_xfer(input logic [6:0] a, input logic [7:0] r, input int n,
                          input int nk, input int st, input bit arb, input bit poke);
    int t;
    int nn;
    nn = (n == 0) ? 1 : n;
    nack_at = nk; stretch_len = st; arb_en = arb;
    got.delete(); mack_q.delete(); exp_q.delete();
    starts = 0; rs_cnt = 0; stops = 0; tx_k = 0;
    done_cnt = 0; hi_run = 0; min_high = 1000000;
    if (nk == 0 && !arb)
      for (int k = 0; k < nn; k++) exp_q.push_back(tgt_byte(k));
    @(negedge clk);
    addr = a; regi = r; cnt = CNT_W'(n); start = 1'b1; busy = 1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      addr = a ^ 7'h15; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 40000) begin @(negedge clk); t++; end
    chk(done, "R9", "done seen", done, 1);
    chk(err == (nk != 0 || arb), "R7", "err at done", err, (nk != 0 || arb));
    if (nk == 0 && !arb) begin
      chk(got.size() == 3, "R2", "bytes seen by target", got.size(), 3);
      if (got.size() == 3) begin
        chk(got[0] == {a, 1'b0}, "R1", "write address byte", got[0], {a, 1'b0});
        chk(got[1] == r, "R2", "register index", got[1], r);
        chk(got[2] == {a, 1'b1}, "R1", "read address byte", got[2], {a, 1'b1});
      end
      chk(rs_cnt == 1, "R2", "repeated start count", rs_cnt, 1);
      chk(starts == 2 && stops == 1, "R3", "start/stop events", starts * 16 + stops, 33);
      chk(mack_q.size() == nn, "R4", "ack slots driven", mack_q.size(), nn);
      for (int i = 0; i < mack_q.size(); i++)
        chk(mack_q[i] == (i != nn - 1), "R4", "master ack bit", mack_q[i], (i != nn - 1));
      chk(exp_q.size() == 0, "R5", "bytes left unread", exp_q.size(), 0);
      chk(scl_line && sda_line, "R9", "bus idle at done", {scl_line, sda_line}, 3);
    end else if (nk != 0) begin
      chk(got.size() == nk, "R7", "bytes before abort", got.size(), nk);
      chk(stops == 1, "R7", "stop after nack", stops, 1);
    end else begin
      chk(stops == 0, "R8", "no stop on arb loss", stops, 0);
      chk(!scl_pull && !sda_pull, "R8", "pulls released", {scl_pull, sda_pull}, 0);
    end
    if (st > 0) chk(min_high >= HALF, "R6", "min SCL high time", min_high, HALF);
    @(negedge clk);
    chk(!done, "R9", "done width", done, 0);
    busy = 0;
    arb_en = 0;
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, poke ? "R10" : "R9", "done pulses per transfer", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R11", "pulls in reset", {scl_pull, sda_pull}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R11", "pulls after reset", {scl_pull, sda_pull}, 0);
    chk(!done && !rd_valid, "R11", "strobes after reset", {done, rd_valid}, 0);

    run_xfer(7'h68, 8'h75, 1, 0, 0, 0, 0);  // R1 R2 single byte
    run_xfer(7'h2A, 8'h00, 4, 0, 0, 0, 0);  // R4 R5 burst
    run_xfer(7'h48, 8'hFA, 3, 0, 25, 0, 0); // R6 stretching target
    run_xfer(7'h11, 8'h3C, 0, 0, 0, 0, 0);  // R4 zero count as one
    run_xfer(7'h68, 8'h75, 2, 1, 0, 0, 0);  // R7 nack write address
    run_xfer(7'h68, 8'h75, 2, 2, 0, 0, 0);  // R7 nack index
    run_xfer(7'h68, 8'h75, 2, 3, 0, 0, 0);  // R7 nack read address
    run_xfer(7'h68, 8'h75, 2, 0, 0, 1, 0);  // R8 lost arbitration
    run_xfer(7'h50, 8'h10, 2, 0, 0, 0, 1);  // R10 start while busy

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule